// File: doc/BRIEF.md
# Packed SIMD Saturating Lane ALU

This unit treats a 32-bit operand pair as four independent 8-bit lanes or two independent 16-bit lanes. It applies one lane operation to every lane at once: add, subtract, halving add, halving subtract, absolute value, left shift, logical right shift or arithmetic right shift. Each lane is sign- or zero-extended before the arithmetic. Saturation and rounding can be switched on or off for each operation.

Next to the packed result, the unit emits a set-mask for the overflow field of a control register. The surrounding datapath ORs this mask into its copy of the register. Because of that merge, overflow bits are sticky: this unit can raise them but never lower them. One operation is taken per cycle. The result and mask are registered and appear on the cycle after the request.

Top module: `simd_lane_alu`

## Requirements
- R1: A request with `in_valid` high yields `out_valid`, `result` and `flag_set` one clock later. Lane i occupies bits [w*(i+1)-1 : w*i], with w=8 when `half_mode`=0 and w=16 when `half_mode`=1. Reset clears all three outputs.
- R2: Add and subtract with `is_signed`=1 and `sat_en`=1 clamp each lane to the range [-2^(w-1), 2^(w-1)-1]. Any clamped lane raises bit 20 of `flag_set`.
- R3: Add and subtract with `is_signed`=0 and `sat_en`=1 clamp each lane to [0, 2^w-1] and raise bit 20 on a clamp.
- R4: With `sat_en`=0, an out-of-range add, subtract or left shift keeps the low w bits of the exact result. The overflow bit is still raised.
- R5: Halving add (`op`=2) and halving subtract (`op`=3) return (a±b+rnd)>>1, computed exactly and shifted arithmetically, where rnd is `rnd_en`. They never set any bit of `flag_set`.
- R6: Absolute value (`op`=4) always reads lanes as signed. The most negative lane value returns the most positive value and raises bit 20. Every other value returns its magnitude.
- R7: Shift ops use only the low log2(w) bits of `shamt`: 3 bits for byte lanes and 4 bits for halfword lanes.
- R8: Left shift (`op`=5) saturates or wraps under the same signed or unsigned range rules as add. Its overflow raises bit 22 of `flag_set`, never bit 20.
- R9: Logical right shift (`op`=6) reads lanes as unsigned. Arithmetic right shift (`op`=7) reads lanes as signed. With `rnd_en`=1 and a non-zero amount s, arithmetic right shift adds 2^(s-1) before shifting.
- R10: Op codes are add=0 and sub=1. `flag_set` is zero on every cycle that carries no result. Only add, sub and abs may set bit 20, and only left shift may set bit 22.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| op | input | 3 | Lane operation code |
| half_mode | input | 1 | 0: four 8-bit lanes, 1: two 16-bit lanes |
| is_signed | input | 1 | Lane signedness for add, sub, halving ops and left shift |
| sat_en | input | 1 | Clamp instead of wrap |
| rnd_en | input | 1 | Rounding for halving ops and arithmetic right shift |
| shamt | input | 4 | Shift amount, masked per lane width |
| opa | input | 32 | First packed operand |
| opb | input | 32 | Second packed operand |
| out_valid | output | 1 | Result strobe |
| result | output | 32 | Packed lane result |
| flag_set | output | 32 | Overflow bits to OR into the control register |

## Verification
The bench sweeps every operation under every combination of lane width, signedness, saturation and rounding. Its lane patterns include 0x80, 0x7f, 0xff and 0x00, so boundary sums and differences come up in every lane position.

The sweep targets the following faults:
- A design that clamps unsigned lanes to the signed range, or that checks the range after truncating to w bits, returns a wrong value or drops the overflow flag.
- A design that forgets to flag overflow in wrapping mode, or that flags overflow on halving ops, is caught through the flag mask.
- Putting the shift overflow on the add/sub bit is caught through the flag mask.
- A design that uses bit 3 of the shift amount in byte mode shifts lanes to zero.
- Absolute value of the most negative lane is checked directly: a design without the special case returns the operand unchanged.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_HADD = 3'd2,
    OP_HSUB = 3'd3,
    OP_ABS  = 3'd4,
    OP_SHL  = 3'd5,
    OP_SHRL = 3'd6,
    OP_SHRA = 3'd7
  } lane_op_e;
endpackage

// File: rtl/simd_lane.sv
module simd_lane
  import simd_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  lane_op_e             op,
  input  logic                 sgn,
  input  logic                 sat,
  input  logic                 rnd,
  input  logic [W-1:0]         a,
  input  logic [W-1:0]         b,
  input  logic [$clog2(W)-1:0] sa,
  output logic [W-1:0]         res,
  output logic                 ovf
);
  localparam int E = 2 * W + 1;

  logic signed [E-1:0] ea_s, ea_u, eb_s, eb_u, ea, eb;
  logic signed [E-1:0] lim_hi, lim_lo, smax, smin, wide, rndv, half;
  logic [E-1:0]        one_sh;
  logic                chk, hi, lo;

  always_comb begin
    ea_s   = $signed({{(E-W){a[W-1]}}, a});
    eb_s   = $signed({{(E-W){b[W-1]}}, b});
    ea_u   = $signed({{(E-W){1'b0}}, a});
    eb_u   = $signed({{(E-W){1'b0}}, b});
    ea     = sgn ? ea_s : ea_u;
    eb     = sgn ? eb_s : eb_u;
    smax   = $signed({{(E-W+1){1'b0}}, {(W-1){1'b1}}});
    smin   = $signed({{(E-W+1){1'b1}}, {(W-1){1'b0}}});
    lim_hi = sgn ? smax : $signed({{(E-W){1'b0}}, {W{1'b1}}});
    lim_lo = sgn ? smin : '0;
    rndv   = rnd ? $signed({{(E-1){1'b0}}, 1'b1}) : '0;
    one_sh = ({{(E-1){1'b0}}, 1'b1} << sa) >> 1;
    half   = rnd ? $signed(one_sh) : '0;
    chk    = 1'b0;
    ovf    = 1'b0;
    case (op)
      OP_ADD:  begin wide = ea + eb; chk = 1'b1; end
      OP_SUB:  begin wide = ea - eb; chk = 1'b1; end
      OP_HADD: wide = (ea + eb + rndv) >>> 1;
      OP_HSUB: wide = (ea - eb + rndv) >>> 1;
      OP_ABS: begin
        if (ea_s == smin) begin
          wide = smax;
          ovf  = 1'b1;
        end else begin
          wide = (ea_s < 0) ? -ea_s : ea_s;
        end
      end
      OP_SHL:  begin wide = ea <<< sa; chk = 1'b1; end
      OP_SHRL: wide = ea_u >> sa;
      OP_SHRA: wide = (ea_s + half) >>> sa;
      default: wide = '0;
    endcase
    hi = chk && (wide > lim_hi);
    lo = chk && (wide < lim_lo);
    if (hi || lo) ovf = 1'b1;
    if (sat && hi) wide = lim_hi;
    else if (sat && lo) wide = lim_lo;
    res = wide[W-1:0];
  end
endmodule

// File: rtl/simd_flag_map.sv
module simd_flag_map
  import simd_alu_pkg::*;
#(
  parameter int CTRL_W    = 32,
  parameter int FLAG_BASE = 16,
  parameter int ARITH_OFS = 4,
  parameter int SHIFT_OFS = 6,
  parameter int NL        = 4
) (
  input  lane_op_e          op,
  input  logic [NL-1:0]     lane_ovf,
  output logic [CTRL_W-1:0] mask
);
  localparam int ARITH_BIT = FLAG_BASE + ARITH_OFS;
  localparam int SHIFT_BIT = FLAG_BASE + SHIFT_OFS;

  logic any_ovf;

  always_comb begin
    any_ovf = |lane_ovf;
    mask    = '0;
    case (op)
      OP_ADD, OP_SUB, OP_ABS: mask[ARITH_BIT] = any_ovf;
      OP_SHL:                 mask[SHIFT_BIT] = any_ovf;
      default:                mask            = '0;
    endcase
  end
endmodule

// File: rtl/simd_lane_alu.sv
module simd_lane_alu
  import simd_alu_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NARROW_W  = 8,
  parameter int WIDE_W    = 16,
  parameter int CTRL_W    = 32,
  parameter int FLAG_BASE = 16,
  parameter int ARITH_OFS = 4,
  parameter int SHIFT_OFS = 6,
  parameter int SH_W      = $clog2(WIDE_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [2:0]        op,
  input  logic              half_mode,
  input  logic              is_signed,
  input  logic              sat_en,
  input  logic              rnd_en,
  input  logic [SH_W-1:0]   shamt,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic [CTRL_W-1:0] flag_set
);
  localparam int NB    = DATA_W / NARROW_W;
  localparam int NH    = DATA_W / WIDE_W;
  localparam int NSA_W = $clog2(NARROW_W);
  localparam int ARITH_BIT = FLAG_BASE + ARITH_OFS;
  localparam int SHIFT_BIT = FLAG_BASE + SHIFT_OFS;

  lane_op_e          op_e;
  logic [DATA_W-1:0] byte_res, half_res, res_nxt;
  logic [NB-1:0]     byte_ovf, sel_ovf;
  logic [NH-1:0]     half_ovf;
  logic [CTRL_W-1:0] mask_nxt;

  assign op_e = lane_op_e'(op);

  for (genvar i = 0; i < NB; i++) begin : g_byte
    simd_lane #(.W(NARROW_W)) u_lane (
      .op(op_e), .sgn(is_signed), .sat(sat_en), .rnd(rnd_en),
      .a(opa[NARROW_W*i +: NARROW_W]), .b(opb[NARROW_W*i +: NARROW_W]),
      .sa(shamt[NSA_W-1:0]),
      .res(byte_res[NARROW_W*i +: NARROW_W]), .ovf(byte_ovf[i])
    );
  end

  for (genvar i = 0; i < NH; i++) begin : g_half
    simd_lane #(.W(WIDE_W)) u_lane (
      .op(op_e), .sgn(is_signed), .sat(sat_en), .rnd(rnd_en),
      .a(opa[WIDE_W*i +: WIDE_W]), .b(opb[WIDE_W*i +: WIDE_W]),
      .sa(shamt),
      .res(half_res[WIDE_W*i +: WIDE_W]), .ovf(half_ovf[i])
    );
  end

  assign res_nxt = half_mode ? half_res : byte_res;
  assign sel_ovf = half_mode ? NB'(half_ovf) : byte_ovf;

  simd_flag_map #(
    .CTRL_W(CTRL_W), .FLAG_BASE(FLAG_BASE), .ARITH_OFS(ARITH_OFS),
    .SHIFT_OFS(SHIFT_OFS), .NL(NB)
  ) u_flags (
    .op(op_e), .lane_ovf(sel_ovf), .mask(mask_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      flag_set  <= '0;
    end else begin
      out_valid <= in_valid;
      flag_set  <= in_valid ? mask_nxt : '0;
      if (in_valid) result <= res_nxt;
    end
  end

  p_valid_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_idle_noflag_r10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && flag_set == '0));

  p_halving_noflag_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (op == OP_HADD || op == OP_HSUB)) |=> (flag_set == '0));

  p_shift_flagbit_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OP_SHL) |=> !flag_set[ARITH_BIT]);

  p_arith_flagbit_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (op == OP_ADD || op == OP_SUB)) |=> !flag_set[SHIFT_BIT]);

  p_abs_min_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OP_ABS && !half_mode && opa[NARROW_W-1:0] == {1'b1, {(NARROW_W-1){1'b0}}})
    |=> (result[NARROW_W-1:0] == {1'b0, {(NARROW_W-1){1'b1}}} && flag_set[ARITH_BIT]));

  p_flag_single_r10: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $onehot0(flag_set));
endmodule

// File: tb/simd_lane_alu_test.sv
`timescale 1ns/1ps
module simd_lane_alu_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  op = '0;
  logic        half_mode = 1'b0, is_signed = 1'b0, sat_en = 1'b0, rnd_en = 1'b0;
  logic [3:0]  shamt = '0;
  logic [31:0] opa = '0, opb = '0;
  logic        out_valid;
  logic [31:0] result, flag_set;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  simd_lane_alu uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .half_mode(half_mode),
    .is_signed(is_signed), .sat_en(sat_en), .rnd_en(rnd_en), .shamt(shamt),
    .opa(opa), .opb(opb), .out_valid(out_valid), .result(result), .flag_set(flag_set)
  );

  byte unsigned pat [16] = '{8'h00, 8'h01, 8'h02, 8'h7e, 8'h7f, 8'h80, 8'h81, 8'hfe,
                             8'hff, 8'h40, 8'h3f, 8'hc0, 8'h55, 8'haa, 8'h10, 8'hf0};

  task automatic lane_model(input int o, input int w, input bit sg, input bit st,
                            input bit rn, input longint a, input longint b, input int s_in,
                            output longint res, output bit ovf);
    longint full, ea, eb, as_, au, mx, mn, r;
    int s;
    full = longint'(1) << w;
    s    = s_in & (w - 1);
    as_  = a[w-1] ? a - full : a;
    au   = a;
    ea   = sg ? as_ : a;
    eb   = sg ? (b[w-1] ? b - full : b) : b;
    mx   = sg ? (full / 2) - 1 : full - 1;
    mn   = sg ? -(full / 2) : 0;
    ovf  = 1'b0;
    case (o)
      0, 1, 5: begin
        r = (o == 0) ? ea + eb : (o == 1) ? ea - eb : ea * (longint'(1) << s);
        if (r > mx) begin ovf = 1'b1; if (st) r = mx; end
        else if (r < mn) begin ovf = 1'b1; if (st) r = mn; end
      end
      2: r = (ea + eb + longint'(rn)) >>> 1;
      3: r = (ea - eb + longint'(rn)) >>> 1;
      4: begin
        if (as_ == -(full / 2)) begin r = (full / 2) - 1; ovf = 1'b1; end
        else r = (as_ < 0) ? -as_ : as_;
      end
      6: r = au >> s;
      default: r = (rn && s > 0) ? (as_ + (longint'(1) << (s - 1))) >>> s : as_ >>> s;
    endcase
    res = r & (full - 1);
  endtask

  function automatic string tag_of(int o, bit hm, bit sg, bit st, int s);
    if ((o >= 5) && !hm && s[3]) return "R7";
    case (o)
      0, 1:    return st ? (sg ? "R2" : "R3") : "R4";
      2, 3:    return "R5";
      4:       return "R6";
      5:       return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic compare(input string tag, input logic [31:0] exp_r, input logic [31:0] exp_f);
    checks++;
    if (!out_valid || result !== exp_r || flag_set !== exp_f) begin
      fails++;
      $display("FAIL %s: op=%0d half=%0b sgn=%0b sat=%0b rnd=%0b sa=%0d a=%h b=%h got v=%0b r=%h f=%h exp r=%h f=%h",
               tag, op, half_mode, is_signed, sat_en, rnd_en, shamt, opa, opb,
               out_valid, result, flag_set, exp_r, exp_f);
    end
  endtask

  task automatic run_vec(input int o, input bit hm, input bit sg, input bit st, input bit rn,
                         input int sa, input logic [31:0] a, input logic [31:0] b, input string forced_tag);
    logic [31:0] er, ef;
    longint lr;
    bit lo, any;
    int w, nl;
    w  = hm ? 16 : 8;
    nl = 32 / w;
    er = '0;
    any = 1'b0;
    for (int i = 0; i < nl; i++) begin
      lane_model(o, w, sg, st, rn, longint'((a >> (w * i)) & ((32'd1 << w) - 1)),
                 longint'((b >> (w * i)) & ((32'd1 << w) - 1)), sa, lr, lo);
      er = er | (32'(lr) << (w * i));
      any = any | lo;
    end
    ef = '0;
    if (any && (o == 0 || o == 1 || o == 4)) ef[20] = 1'b1;
    if (any && o == 5) ef[22] = 1'b1;
    @(negedge clk);
    op = 3'(o); half_mode = hm; is_signed = sg; sat_en = st; rnd_en = rn;
    shamt = 4'(sa); opa = a; opb = b; in_valid = 1'b1;
    @(negedge clk);
    compare((forced_tag != "") ? forced_tag : tag_of(o, hm, sg, st, sa), er, ef);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || result !== '0 || flag_set !== '0) begin
      fails++;
      $display("FAIL R1: reset state got v=%0b r=%h f=%h expected 0/0/0", out_valid, result, flag_set);
    end

    // R1: lane placement for byte lanes and halfword lanes
    run_vec(0, 1'b0, 1'b0, 1'b0, 1'b0, 0, 32'h04030201, 32'h10203040, "R1");
    run_vec(0, 1'b1, 1'b0, 1'b0, 1'b0, 0, 32'h00020001, 32'h00300040, "R1");
    // R2: signed halfword saturation at the top
    run_vec(0, 1'b1, 1'b1, 1'b1, 1'b0, 0, 32'h00017fff, 32'h00000001, "R2");
    // R6: most negative halfword
    run_vec(4, 1'b1, 1'b1, 1'b0, 1'b0, 0, 32'h80000005, 32'h0, "R6");
    // R8: halfword shift overflow in wrap mode
    run_vec(5, 1'b1, 1'b1, 1'b0, 1'b0, 15, 32'h00010003, 32'h0, "R8");
    // R9: rounding arithmetic right shift of halfwords
    run_vec(7, 1'b1, 1'b0, 1'b0, 1'b1, 4, 32'hfff80018, 32'h0, "R9");

    // R10: idle cycle carries no flags
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || flag_set !== '0) begin
      fails++;
      $display("FAIL R10: idle got v=%0b f=%h expected 0/0", out_valid, flag_set);
    end

    // Sweep: every op, lane width, signedness, saturation and rounding
    for (int o = 0; o < 8; o++)
      for (int cfg = 0; cfg < 16; cfg++)
        for (int ia = 0; ia < 16; ia++)
          for (int ib = 0; ib < 16; ib++) begin
            logic [31:0] a, b;
            bit hm;
            hm = cfg[3];
            if (!hm) begin
              for (int i = 0; i < 4; i++) begin
                a[8*i +: 8] = pat[(ia + i) % 16];
                b[8*i +: 8] = pat[(ib + 3 * i) % 16];
              end
            end else begin
              for (int i = 0; i < 2; i++) begin
                a[16*i +: 16] = {pat[(ia + i) % 16], pat[(ia + 11 + i) % 16]};
                b[16*i +: 16] = {pat[(ib + 2 * i) % 16], pat[(ib + 7 + i) % 16]};
              end
            end
            run_vec(o, hm, cfg[2], cfg[1], cfg[0], (ia ^ ib) & 15, a, b, "");
          end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule